// File: doc/BRIEF.md
# Network Controller Power-Mode Sequencer

This block decides which power mode a single-port network controller is in. It drives four enables: PLL clocks, MAC, PHY transmitter and PHY receiver. The host reaches it through a plain strobe interface with write and read strobes, an address and write data. Two host registers belong to it. The control register holds a 2-bit mode field and an auto-wake bit. The port register holds the enable for automatic power saving.

Writes to the mode field ask for a mode. Each mode has its own exit. Soft power-down ends only when the host reads the wake address. The low-power mode ends on that read, or on line energy when auto-wake is set. Power saving is left automatically when the line shows activity, or by the host rewriting the mode. The mode actually in effect is always visible on a status output.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in normal mode (status 2'b00). All four enables are 1. The mode field, the auto-wake bit and the power-saving enable all read 0.
- R2: A write of mode code 2'b10 in normal mode enters soft power-down on the clock edge after the write is registered. In soft power-down all four enables are 0.
- R3: While in soft power-down or low-power mode, host writes are ignored, so both registers read back unchanged.
- R4: Soft power-down is left only by a read strobe at the wake address (default 0x26). That read returns the block to normal on the next edge and clears the mode field to 2'b00. Line energy, far-end link requests and reads of other addresses leave it in soft power-down.
- R5: Power saving is entered from normal mode only when four conditions hold together: the mode field is 2'b11, the power-saving enable is 1, auto-negotiation is on, and no cable is detected. If any one of them is missing, the block stays in normal mode.
- R6: In power saving, the PLL, MAC and PHY transmitter enables stay 1 and only the PHY receiver enable is 0. Host writes in this mode are still accepted.
- R7: In power saving, line energy or a far-end link request returns the block to normal on the next edge. This takes priority over any other exit.
- R8: In power saving, if the mode field is no longer 2'b11 or the power-saving enable is 0, the block moves to the mode that the field selects (2'b00 goes to normal).
- R9: Mode code 2'b01 selects low-power mode, in which only the PHY receiver enable is 1. A read of the wake address always wakes it. Line energy wakes it only when the auto-wake bit is 1. Either wake clears the mode field.
- R10: The status output gives the mode in effect: 00 normal, 01 low power, 10 soft power-down, 11 power saving.
- R11: A read at any address other than the wake address has no effect on the mode. A read of the wake address has no effect in normal mode or in power saving.
- R12: While the read strobe is high, read data gives the control register with the mode field in bits 1:0 and auto-wake in bit 7, and the port register with the power-saving enable in bit 10. Any other address, or no read strobe, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | AW (8) | Host register address |
| reg_wdata | input | DW (16) | Host write data |
| reg_rdata | output | DW (16) | Host read data, combinational |
| aneg_en | input | 1 | Auto-negotiation enabled |
| cable_det | input | 1 | Cable detected on the line |
| energy_det | input | 1 | Line energy or activity detected |
| far_link_req | input | 1 | Far end attempting to establish link |
| mode_now | output | 2 | Mode in effect |
| pll_en | output | 1 | PLL clock enable |
| mac_en | output | 1 | MAC enable |
| phy_tx_en | output | 1 | PHY transmitter enable |
| phy_rx_en | output | 1 | PHY receiver enable |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 16-bit data, wake address 0x26, control register at 0xD4 and port register at 0xF4. With these values the wake read, the auto-wake bit at position 7 and the power-saving enable at position 10 all fit in the one data word. Every mode transition and every ignored-stimulus case can therefore be reached with ordinary writes and reads. A behavioural model tracks mode, fields and expected enables cycle by cycle, so the cases are exercised along the way. These include the re-entry into power saving after an activity wake while the cable stays absent, and the priority of activity over a simultaneous mode rewrite.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] WAKE_ADDR = 8'h26,
  parameter logic [AW-1:0] CTL_ADDR  = 8'hD4,
  parameter logic [AW-1:0] PORT_ADDR = 8'hF4,
  parameter int AUTO_BIT  = 7,
  parameter int PSAVE_BIT = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          aneg_en,
  input  logic          cable_det,
  input  logic          energy_det,
  input  logic          far_link_req,
  output logic [1:0]    mode_now,
  output logic          pll_en,
  output logic          mac_en,
  output logic          phy_tx_en,
  output logic          phy_rx_en
);
  localparam logic [1:0] ST_RUN  = 2'b00;
  localparam logic [1:0] ST_LOW  = 2'b01;
  localparam logic [1:0] ST_SOFT = 2'b10;
  localparam logic [1:0] ST_SAVE = 2'b11;

  logic [1:0] state, nxt, field;
  logic       auto_wk, ps_en;

  wire wake_rd  = reg_rd && (reg_addr == WAKE_ADDR);
  wire awake    = (state == ST_RUN) || (state == ST_SAVE);
  wire activity = energy_det || far_link_req;
  wire low_wake = (state == ST_LOW) && auto_wk && energy_det;

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:
        if (field == ST_SOFT) nxt = ST_SOFT;
        else if (field == ST_LOW) nxt = ST_LOW;
        else if (field == ST_SAVE && ps_en && aneg_en && !cable_det) nxt = ST_SAVE;
      ST_SAVE:
        if (activity) nxt = ST_RUN;
        else if (!(field == ST_SAVE && ps_en)) nxt = (field == ST_SAVE) ? ST_RUN : field;
      ST_SOFT:
        if (wake_rd) nxt = ST_RUN;
      default:
        if (wake_rd || low_wake) nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      field   <= 2'b00;
      auto_wk <= 1'b0;
      ps_en   <= 1'b0;
    end else begin
      state <= nxt;
      if (awake && reg_wr) begin
        if (reg_addr == CTL_ADDR) begin
          field   <= reg_wdata[1:0];
          auto_wk <= reg_wdata[AUTO_BIT];
        end
        if (reg_addr == PORT_ADDR) ps_en <= reg_wdata[PSAVE_BIT];
      end
      if (!awake && (wake_rd || low_wake)) field <= 2'b00;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && reg_addr == CTL_ADDR) begin
      reg_rdata[1:0]      = field;
      reg_rdata[AUTO_BIT] = auto_wk;
    end
    if (reg_rd && reg_addr == PORT_ADDR) reg_rdata[PSAVE_BIT] = ps_en;
  end

  assign mode_now  = state;
  assign pll_en    = awake;
  assign mac_en    = awake;
  assign phy_tx_en = (state == ST_RUN) || (state == ST_SAVE);
  assign phy_rx_en = (state == ST_RUN) || (state == ST_LOW);

  assert_sleep_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && reg_wr && !wake_rd && !low_wake) |=> ($stable(field) && $stable(ps_en) && $stable(auto_wk)));

  assert_soft_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SOFT && !wake_rd) |=> (state == ST_SOFT));

  assert_soft_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SOFT && wake_rd) |=> (state == ST_RUN && field == 2'b00));

  assert_save_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_SAVE) |-> $past(field == ST_SAVE && ps_en && aneg_en && !cable_det));

  assert_save_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAVE && activity) |=> (state == ST_RUN));

  assert_save_rx_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAVE) |-> (pll_en && mac_en && phy_tx_en && !phy_rx_en));
endmodule

// File: tb/pwr_mode_seq_tb.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb;
  localparam int CTL = 'hD4, PRT = 'hF4, WK = 'h26;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic aneg_en = 0, cable_det = 1, energy_det = 0, far_link_req = 0;
  logic [1:0] mode_now;
  logic pll_en, mac_en, phy_tx_en, phy_rx_en;

  int checks = 0, errors = 0;
  int m_state = 0, m_field = 0, m_auto = 0, m_ps = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .aneg_en(aneg_en), .cable_det(cable_det), .energy_det(energy_det),
    .far_link_req(far_link_req), .mode_now(mode_now), .pll_en(pll_en),
    .mac_en(mac_en), .phy_tx_en(phy_tx_en), .phy_rx_en(phy_rx_en));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    int ns, nf, na, np;
    bit up, wrd;
    ns = m_state; nf = m_field; na = m_auto; np = m_ps;
    up  = (m_state == 0 || m_state == 3);
    wrd = reg_rd && reg_addr == WK;
    if (!rst_n) begin
      ns = 0; nf = 0; na = 0; np = 0;
    end else begin
      if (up && reg_wr && reg_addr == CTL) begin nf = reg_wdata[1:0]; na = reg_wdata[7]; end
      if (up && reg_wr && reg_addr == PRT) np = reg_wdata[10];
      if (m_state == 0) begin
        if (m_field == 2 || m_field == 1) ns = m_field;
        else if (m_field == 3 && m_ps == 1 && aneg_en && !cable_det) ns = 3;
      end else if (m_state == 3) begin
        if (energy_det || far_link_req) ns = 0;
        else if (m_field != 3 || m_ps == 0) ns = (m_field == 3) ? 0 : m_field;
      end else if (m_state == 2) begin
        if (wrd) begin ns = 0; nf = 0; end
      end else begin
        if (wrd || (m_auto == 1 && energy_det)) begin ns = 0; nf = 0; end
      end
    end
    m_state = ns; m_field = nf; m_auto = na; m_ps = np;
  end

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    int exp_rd;
    #1;
    if (rst_n && !done) begin
      chk("R10 mode_now", mode_now, m_state);
      chk("R6 enables", {pll_en, mac_en, phy_tx_en, phy_rx_en},
          (m_state == 0) ? 4'b1111 : (m_state == 1) ? 4'b0001 :
          (m_state == 2) ? 4'b0000 : 4'b1110);
      exp_rd = 0;
      if (reg_rd && reg_addr == CTL) exp_rd = m_field | (m_auto << 7);
      if (reg_rd && reg_addr == PRT) exp_rd = m_ps << 10;
      chk("R12 rdata", reg_rdata, exp_rd);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_wr = 1; reg_addr = a[7:0]; reg_wdata = d[15:0];
    @(negedge clk); reg_wr = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic rd(int a);
    @(negedge clk); reg_rd = 1; reg_addr = a[7:0];
    @(negedge clk); reg_rd = 0; reg_addr = 0;
  endtask

  task automatic peek(string req, int a, int exp);
    @(negedge clk); reg_rd = 1; reg_addr = a[7:0];
    #1 chk(req, reg_rdata, exp);
    @(negedge clk); reg_rd = 0; reg_addr = 0;
  endtask

  task automatic pulse_energy(bit far);
    @(negedge clk); if (far) far_link_req = 1; else energy_det = 1;
    @(negedge clk); far_link_req = 0; energy_det = 0;
  endtask

  task automatic see(string req, int m, int en);
    @(negedge clk); #1;
    chk(req, mode_now, m);
    chk(req, {pll_en, mac_en, phy_tx_en, phy_rx_en}, en);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    see("R1 reset", 0, 4'b1111);
    peek("R1 ctl", CTL, 0);
    peek("R1 port", PRT, 0);

    wr(CTL, 16'h0080);
    peek("R12 ctl auto bit7", CTL, 16'h0080);
    wr(PRT, 16'h0400);
    peek("R12 port bit10", PRT, 16'h0400);
    peek("R12 other addr", 8'h10, 0);

    rd(8'h10); rd(WK);
    see("R11 reads in normal", 0, 4'b1111);

    wr(CTL, 16'h0002); idle(1);
    see("R2 soft pd", 2, 4'b0000);
    wr(CTL, 16'h0000); wr(PRT, 16'h0000);
    peek("R3 ctl held", CTL, 16'h0002);
    peek("R3 port held", PRT, 16'h0400);
    pulse_energy(0); pulse_energy(1); rd(8'h30); rd(CTL);
    see("R4 soft stays", 2, 4'b0000);
    rd(WK);
    see("R4 woke", 0, 4'b1111);
    peek("R4 field cleared", CTL, 0);

    wr(CTL, 16'h0003);
    aneg_en = 0; cable_det = 0; idle(3);
    see("R5 no aneg", 0, 4'b1111);
    aneg_en = 1; cable_det = 1; idle(3);
    see("R5 cable present", 0, 4'b1111);
    wr(PRT, 16'h0000); cable_det = 0; idle(3);
    see("R5 enable off", 0, 4'b1111);
    wr(PRT, 16'h0400); idle(2);
    see("R5 entered", 3, 4'b1110);

    wr(CTL, 16'h0083);
    peek("R6 write in psave", CTL, 16'h0083);
    rd(WK); rd(8'h44);
    see("R11 reads in psave", 3, 4'b1110);

    @(negedge clk); energy_det = 1;
    @(negedge clk); energy_det = 0; #1;
    chk("R7 energy wake", mode_now, 0);
    idle(2);
    see("R7 re-entry", 3, 4'b1110);
    @(negedge clk); far_link_req = 1;
    @(negedge clk); far_link_req = 0; #1;
    chk("R7 far wake", mode_now, 0);
    idle(2);

    // activity and rewrite together: activity wins
    @(negedge clk); reg_wr = 1; reg_addr = CTL; reg_wdata = 16'h0002; energy_det = 1;
    @(negedge clk); reg_wr = 0; reg_addr = 0; reg_wdata = 0; energy_det = 0; #1;
    chk("R7 priority", mode_now, 0);
    idle(1);
    see("R2 soft after", 2, 4'b0000);
    rd(WK); idle(1);

    wr(CTL, 16'h0003); idle(2);
    see("R8 psave again", 3, 4'b1110);
    wr(CTL, 16'h0001); wr(PRT, 16'h0000);
    see("R8 to low", 1, 4'b0001);
    pulse_energy(0); idle(1);
    see("R9 energy no auto", 1, 4'b0001);
    rd(WK);
    see("R9 read wake", 0, 4'b1111);
    peek("R9 field cleared", CTL, 0);

    wr(CTL, 16'h0081); idle(1);
    see("R9 low again", 1, 4'b0001);
    pulse_energy(1); rd(8'h27);
    see("R11 low ignores", 1, 4'b0001);
    pulse_energy(0);
    see("R9 auto wake", 0, 4'b1111);

    cable_det = 1;
    wr(PRT, 16'h0400); wr(CTL, 16'h0003); idle(2);
    see("R8 cable blocks", 0, 4'b1111);
    cable_det = 0; idle(2);
    see("R8 enter", 3, 4'b1110);
    wr(CTL, 16'h0000); idle(1);
    see("R8 to normal", 0, 4'b1111);

    done = 1;
    idle(1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule